// File: doc/BRIEF.md
# Vector-Driven Built-In Self-Test Sequencer

The block runs a self-test when the host asks for one. A host write to a control register starts it. The first phase steps through a read-only vector table, one vector per clock. Each vector names a location in a small simulated register/RAM space and the value that location should hold. The engine reads the location and compares the read value with the expected value.

The second phase is a destructive walking-ones test of the RAM model. For each of the 16 bit positions, the engine first writes every RAM word with that single set bit. It then reads every word back and compares it.

The first mismatch in either phase is recorded in a bank of upper status registers, and a single fail bit reports the overall result. A free-running time-tag counter keeps counting during the whole test. The RAM model takes parameters that force a stuck-at-0 cell, so a failing memory can be built on purpose.

The host address space is laid out as follows:

- Address 0: control register. It is write-only and reads as 0.
- Addresses 1..31: scratch registers.
- Addresses 32..63: upper status bank.
- Addresses 128..255: RAM words 0..127.
- All other addresses read as 0.

Top module: `bist_seq`

## Requirements
- R1: After reset the following hold. `busy_o`, `done_o` and `fail_o` are 0. The status registers 32..36 read 0. Scratch register a (1..31) reads {a XOR 8'h5A, NOT a}, with the high byte first. Every RAM word reads 0.
- R2: A host write to address 0 with data bit 0 set starts a test, but only while the block is idle. `busy_o` is then high for exactly ROM_DEPTH + 32*128 cycles. `done_o` pulses for the single cycle that follows.
- R3: Vector k (0..ROM_DEPTH-1) is 24 bits wide. Bits 23:16 hold the target address, 1 + (k mod 31). Bits 15:0 hold the expected value, which is the R1 reset value of that scratch register. Vectors are checked one per cycle in increasing k.
- R4: `fail_o` and bit 0 of register 36 are 0 for pass and 1 for fail. Bit 1 of register 36 mirrors `busy_o`. A failure appears on `fail_o` the cycle after the mismatching compare.
- R5: At the first mismatch, four values are latched. The failing index goes to register 32. The expected value goes to register 33. The target address goes to register 34. The value actually read goes to register 35. Later mismatches leave all four unchanged. They, together with the fail bit, are cleared when the next test starts.
- R6: The RAM phase runs bit positions b = 0..15 in order. For each b it writes every word with 1<<b, then reads every word back. A RAM mismatch records index 16'h8000 OR b, expected 1<<b, address 128 + word, and the value read.
- R7: The RAM phase is destructive. After a complete test, every RAM word holds 16'h8000, whether the test passed or failed.
- R8: Register 37 is a 16-bit time tag. It equals the number of clock edges since reset, modulo 2^16, and it keeps counting during a test.
- R9: While busy, three kinds of host write are ignored. These are writes to scratch registers, writes to RAM, and start commands.
- R10: A write to address 0 with data bit 1 set has three effects. It stops a running test at once, with no `done_o` pulse. It clears the fail bit and registers 32..35. It takes priority over bit 0 in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | Host address for both reads and writes |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational read data at `host_addr` |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | One-cycle pulse when a test completes |
| fail_o | output | 1 | Overall result, where 1 means a failure |

## Verification
The assertions check the following on every cycle:

- The latched failure record stays frozen once the fail bit is set, until a start or abort arrives.
- Every engine RAM write carries exactly one set bit.
- The scratch registers stay unchanged whenever the host writes during a test.
- The done pulse only ever follows a busy cycle.
- The fail bit only rises out of a busy cycle.

The bench scenarios are needed for everything that depends on the stimulus:

- The exact test length and fail cycle against a reference count.
- The contents of the capture registers after an injected register fault and after a stuck RAM cell.
- That a later mismatch does not overwrite the first one.
- The destroyed RAM contents.
- The effect of an abort.
- The time-tag value.

// File: rtl/bist_pkg.sv
package bist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROM,
        ST_RWR,
        ST_RRD
    } eng_state_e;

    typedef struct packed {
        logic [15:0] idx;
        logic [15:0] expv;
        logic [15:0] addr;
        logic [15:0] act;
    } fail_rec_t;

    function automatic logic [15:0] scratch_init(input logic [7:0] a);
        return {a ^ 8'h5A, ~a};
    endfunction

endpackage

// File: rtl/bist_vrom.sv
module bist_vrom #(
    parameter int ROM_DEPTH = 4096,
    parameter int IDX_W     = $clog2(ROM_DEPTH),
    parameter int SCR_N     = 31
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [23:0]      vec_o
);
    // Vector content is computed from the index rather than stored.
    always_comb begin
        int a;
        a = 1 + (int'(idx_i) % SCR_N);
        vec_o = {8'(a), bist_pkg::scratch_init(8'(a))};
    end
endmodule

// File: rtl/bist_store.sv
module bist_store #(
    parameter int SCR_N      = 31,
    parameter int RAM_AW     = 7,
    parameter int DW         = 16,
    parameter bit FAULT_EN   = 1'b0,
    parameter int FAULT_WORD = 0,
    parameter int FAULT_BIT  = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy_i,
    input  logic          host_we_i,
    input  logic [7:0]    host_addr_i,
    input  logic [DW-1:0] host_data_i,
    input  logic          eng_we_i,
    input  logic [7:0]    eng_addr_i,
    input  logic [DW-1:0] eng_data_i,
    input  logic [7:0]    ra_addr_i,
    output logic [DW-1:0] ra_data_o,
    input  logic [7:0]    rb_addr_i,
    output logic [DW-1:0] rb_data_o
);
    localparam int RAM_N = 2 ** RAM_AW;
    localparam int SW    = $clog2(SCR_N + 1);

    typedef struct packed {
        logic [SCR_N:1][DW-1:0]   scr;
        logic [RAM_N-1:0][DW-1:0] ram;
    } store_t;

    store_t st_d, st_q, st_rst;
    logic [SCR_N:1][DW-1:0] init_w;

    for (genvar g = 1; g <= SCR_N; g++) begin : g_init
        assign init_w[g] = DW'(bist_pkg::scratch_init(8'(g)));
    end

    assign st_rst.scr = init_w;
    assign st_rst.ram = '0;

    function automatic logic scr_hit(input logic [7:0] a);
        return (a != 8'd0) && (int'(a) <= SCR_N) && !a[7];
    endfunction

    function automatic logic [DW-1:0] rd(input logic [7:0] a, input store_t s);
        logic [DW-1:0] w;
        w = '0;
        if (a[7]) begin
            w = s.ram[a[RAM_AW-1:0]];
            if (FAULT_EN && (int'(a[RAM_AW-1:0]) == FAULT_WORD)) w[FAULT_BIT] = 1'b0;
        end else if (scr_hit(a)) begin
            w = s.scr[SW'(a)];
        end
        return w;
    endfunction

    always_comb begin
        st_d = st_q;
        if (eng_we_i) begin
            st_d.ram[eng_addr_i[RAM_AW-1:0]] = eng_data_i;
        end else if (host_we_i && !busy_i) begin
            if (host_addr_i[7]) st_d.ram[host_addr_i[RAM_AW-1:0]] = host_data_i;
            else if (scr_hit(host_addr_i)) st_d.scr[SW'(host_addr_i)] = host_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= st_rst;
        else        st_q <= st_d;
    end

    assign ra_data_o = rd(ra_addr_i, st_q);
    assign rb_data_o = rd(rb_addr_i, st_q);

    assert_host_write_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && host_we_i) |=> (st_q.scr == $past(st_q.scr)));

    assert_walking_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we_i |-> ($countones(eng_data_i) == 1));
endmodule

// File: rtl/bist_engine.sv
module bist_engine #(
    parameter int ROM_DEPTH = 4096,
    parameter int IDX_W     = $clog2(ROM_DEPTH),
    parameter int RAM_AW    = 7,
    parameter int DW        = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                abort_i,
    input  logic [23:0]         vec_i,
    output logic [IDX_W-1:0]    rom_idx_o,
    output logic [7:0]          tgt_addr_o,
    input  logic [DW-1:0]       rd_data_i,
    output logic                eng_we_o,
    output logic [7:0]          eng_addr_o,
    output logic [DW-1:0]       eng_data_o,
    output bist_pkg::fail_rec_t rec_o,
    output logic                fail_o,
    output logic                busy_o,
    output logic                done_o
);
    import bist_pkg::*;

    localparam int BIT_W = $clog2(DW);
    localparam logic [RAM_AW-1:0] PTR_LAST = RAM_AW'(2 ** RAM_AW - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(ROM_DEPTH - 1);
    localparam logic [BIT_W-1:0]  BIT_LAST = BIT_W'(DW - 1);

    typedef struct packed {
        eng_state_e       state;
        logic [IDX_W-1:0] idx;
        logic [RAM_AW-1:0] ptr;
        logic [BIT_W-1:0] bitp;
        logic             fail;
        logic             done;
        fail_rec_t        rec;
    } eng_t;

    eng_t e_d, e_q;
    logic [DW-1:0] walk_w, exp_w;
    logic          cmp_en, mism;

    assign walk_w     = {{(DW-1){1'b0}}, 1'b1} << e_q.bitp;
    assign exp_w      = (e_q.state == ST_ROM) ? vec_i[DW-1:0] : walk_w;
    assign tgt_addr_o = (e_q.state == ST_ROM) ? vec_i[23:16] : (8'h80 | 8'(e_q.ptr));
    assign cmp_en     = (e_q.state == ST_ROM) || (e_q.state == ST_RRD);
    assign mism       = cmp_en && (rd_data_i != exp_w);

    always_comb begin
        e_d      = e_q;
        e_d.done = 1'b0;
        unique case (e_q.state)
            ST_IDLE: begin
                if (abort_i) begin
                    e_d.fail = 1'b0;
                    e_d.rec  = '0;
                end else if (start_i) begin
                    e_d.state = ST_ROM;
                    e_d.idx   = '0;
                    e_d.fail  = 1'b0;
                    e_d.rec   = '0;
                end
            end
            ST_ROM: begin
                if (e_q.idx == IDX_LAST) begin
                    e_d.state = ST_RWR;
                    e_d.ptr   = '0;
                    e_d.bitp  = '0;
                end else begin
                    e_d.idx = e_q.idx + 1'b1;
                end
            end
            ST_RWR: begin
                e_d.ptr = e_q.ptr + 1'b1;
                if (e_q.ptr == PTR_LAST) e_d.state = ST_RRD;
            end
            ST_RRD: begin
                e_d.ptr = e_q.ptr + 1'b1;
                if (e_q.ptr == PTR_LAST) begin
                    if (e_q.bitp == BIT_LAST) begin
                        e_d.state = ST_IDLE;
                        e_d.done  = 1'b1;
                    end else begin
                        e_d.bitp  = e_q.bitp + 1'b1;
                        e_d.state = ST_RWR;
                    end
                end
            end
            default: e_d.state = ST_IDLE;
        endcase

        if (mism && !e_q.fail) begin
            e_d.fail     = 1'b1;
            e_d.rec.idx  = (e_q.state == ST_ROM) ? 16'(e_q.idx) : (16'h8000 | 16'(e_q.bitp));
            e_d.rec.expv = 16'(exp_w);
            e_d.rec.addr = 16'(tgt_addr_o);
            e_d.rec.act  = 16'(rd_data_i);
        end

        if (abort_i && (e_q.state != ST_IDLE)) begin
            e_d.state = ST_IDLE;
            e_d.done  = 1'b0;
            e_d.fail  = 1'b0;
            e_d.rec   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q       <= '0;
            e_q.state <= ST_IDLE;
        end else begin
            e_q <= e_d;
        end
    end

    assign rom_idx_o  = e_q.idx;
    assign eng_we_o   = (e_q.state == ST_RWR);
    assign eng_addr_o = 8'h80 | 8'(e_q.ptr);
    assign eng_data_o = walk_w;
    assign rec_o      = e_q.rec;
    assign fail_o     = e_q.fail;
    assign busy_o     = (e_q.state != ST_IDLE);
    assign done_o     = e_q.done;

    assert_first_fail_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.fail && !abort_i && !start_i) |=> $stable(e_q.rec));
endmodule

// File: rtl/bist_seq.sv
module bist_seq #(
    parameter int ROM_DEPTH  = 4096,
    parameter int SCR_N      = 31,
    parameter int RAM_AW     = 7,
    parameter bit FAULT_EN   = 1'b0,
    parameter int FAULT_WORD = 0,
    parameter int FAULT_BIT  = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_we,
    input  logic [7:0]  host_addr,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        busy_o,
    output logic        done_o,
    output logic        fail_o
);
    localparam int IDX_W = $clog2(ROM_DEPTH);
    localparam int DW    = 16;

    logic [IDX_W-1:0]    rom_idx;
    logic [23:0]         vec;
    logic [7:0]          tgt_addr, eng_addr;
    logic [DW-1:0]       tgt_data, eng_data, rb_data;
    logic                eng_we, ctl_hit;
    bist_pkg::fail_rec_t rec;
    logic [15:0]         tt_d, tt_q;
    logic [15:0]         upper_w;

    assign ctl_hit = host_we && (host_addr == 8'd0);

    bist_vrom #(.ROM_DEPTH(ROM_DEPTH), .IDX_W(IDX_W), .SCR_N(SCR_N)) u_vrom (
        .idx_i (rom_idx),
        .vec_o (vec)
    );

    bist_engine #(.ROM_DEPTH(ROM_DEPTH), .IDX_W(IDX_W), .RAM_AW(RAM_AW), .DW(DW)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (ctl_hit && host_wdata[0]),
        .abort_i    (ctl_hit && host_wdata[1]),
        .vec_i      (vec),
        .rom_idx_o  (rom_idx),
        .tgt_addr_o (tgt_addr),
        .rd_data_i  (tgt_data),
        .eng_we_o   (eng_we),
        .eng_addr_o (eng_addr),
        .eng_data_o (eng_data),
        .rec_o      (rec),
        .fail_o     (fail_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    bist_store #(.SCR_N(SCR_N), .RAM_AW(RAM_AW), .DW(DW), .FAULT_EN(FAULT_EN),
                 .FAULT_WORD(FAULT_WORD), .FAULT_BIT(FAULT_BIT)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy_o),
        .host_we_i   (host_we),
        .host_addr_i (host_addr),
        .host_data_i (host_wdata),
        .eng_we_i    (eng_we),
        .eng_addr_i  (eng_addr),
        .eng_data_i  (eng_data),
        .ra_addr_i   (tgt_addr),
        .ra_data_o   (tgt_data),
        .rb_addr_i   (host_addr),
        .rb_data_o   (rb_data)
    );

    // Free-running time tag.
    always_comb tt_d = tt_q + 16'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tt_q <= '0;
        else        tt_q <= tt_d;
    end

    always_comb begin
        unique case (host_addr[4:0])
            5'd0:    upper_w = rec.idx;
            5'd1:    upper_w = rec.expv;
            5'd2:    upper_w = rec.addr;
            5'd3:    upper_w = rec.act;
            5'd4:    upper_w = {14'd0, busy_o, fail_o};
            5'd5:    upper_w = tt_q;
            default: upper_w = '0;
        endcase
    end

    assign host_rdata = (host_addr[7:5] == 3'b001) ? upper_w : rb_data;

    assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_fail_rises_in_test_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> $past(busy_o));
endmodule

// File: tb/bist_seq_test.sv
module bist_seq_test;
    localparam int N     = 4096;
    localparam int TOTAL = N + 2 * 16 * 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = 8'd0;
    logic [15:0] host_wdata = 16'd0;
    logic [15:0] host_rdata, f_rdata;
    logic        busy_o, done_o, fail_o, f_busy, f_done, f_fail;

    int errs = 0, checks = 0;
    int cyc = 0, steps = 0, fail_step = -1;
    bit m_busy = 0, m_done = 0, m_fail = 0;

    always #5 clk = ~clk;

    bist_seq uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o));

    bist_seq #(.FAULT_EN(1'b1), .FAULT_WORD(10), .FAULT_BIT(3)) uut_ram (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(f_rdata),
        .busy_o(f_busy), .done_o(f_done), .fail_o(f_fail));

    function automatic logic [15:0] init_val(input int a);
        logic [7:0] b;
        b = 8'(a);
        return {b ^ 8'h5A, ~b};
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Behavioural reference: counts edges since the start command.
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; m_busy = 0; m_done = 0; m_fail = 0; steps = 0;
        end else begin
            cyc++;
            m_done = 0;
            if (m_busy) begin
                if (host_we && host_addr == 0 && host_wdata[1]) begin
                    m_busy = 0; m_fail = 0;
                end else begin
                    steps++;
                    if (fail_step >= 0 && steps == fail_step) m_fail = 1;
                    if (steps == TOTAL) begin m_busy = 0; m_done = 1; end
                end
            end else if (host_we && host_addr == 0) begin
                if (host_wdata[1]) m_fail = 0;
                else if (host_wdata[0]) begin m_busy = 1; steps = 0; m_fail = 0; end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 busy", int'(busy_o), int'(m_busy));
            check("R2 done", int'(done_o), int'(m_done));
            check("R4 fail", int'(fail_o), int'(m_fail));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 8'(a); host_wdata = 16'(d);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v, output int fv);
        @(negedge clk);
        host_addr = 8'(a);
        #1;
        v = int'(host_rdata);
        fv = int'(f_rdata);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks + 1);
        $finish;
    end

    initial begin
        int v, fv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 busy", int'(busy_o), 0);
        check("R1 fail", int'(fail_o), 0);
        for (int a = 32; a <= 36; a++) begin rd(a, v, fv); check("R1 status", v, 0); end
        rd(5, v, fv);   check("R1 scratch", v, int'(init_val(5)));
        rd(31, v, fv);  check("R1 scratch", v, int'(init_val(31)));
        rd(138, v, fv); check("R1 ram", v, 0);
        rd(37, v, fv);  check("R8 tag", v, cyc & 16'hFFFF);

        // Clean run: host writes and restart during busy are ignored (R9)
        fail_step = -1;
        wr(0, 1);
        repeat (50) @(negedge clk);
        wr(7, 16'hDEAD);
        wr(0, 1);
        rd(36, v, fv);  check("R4 busy bit", v, 2);
        rd(37, v, fv);  check("R8 tag in test", v, cyc & 16'hFFFF);
        repeat (TOTAL + 5) @(negedge clk);
        check("R4 pass", int'(fail_o), 0);
        rd(36, v, fv);  check("R4 status", v, 0);
        rd(7, v, fv);   check("R9 scratch kept", v, int'(init_val(7)));
        rd(128, v, fv); check("R7 ram0", v, 16'h8000);
        rd(200, v, fv); check("R7 ram72", v, 16'h8000);
        rd(255, v, fv); check("R7 ram127", v, 16'h8000);
        // Stuck cell instance: first RAM failure at bit 3, word 10 (R6)
        check("R6 fault fail", int'(f_fail), 1);
        rd(32, v, fv);  check("R6 idx", fv, 16'h8003);
        rd(33, v, fv);  check("R6 expected", fv, 16'h0008);
        rd(34, v, fv);  check("R6 addr", fv, 138);
        rd(35, v, fv);  check("R6 actual", fv, 0);
        rd(138, v, fv); check("R7 faulty ram", fv, 16'h8000 & ~16'h0008);

        // Injected register fault: first failing vector k=4 (R3, R5)
        wr(5, 16'h1234);
        fail_step = 5;
        wr(0, 1);
        repeat (TOTAL + 5) @(negedge clk);
        rd(32, v, fv);  check("R5 idx", v, 4);
        rd(33, v, fv);  check("R5 expected", v, int'(init_val(5)));
        rd(34, v, fv);  check("R5 addr", v, 5);
        rd(35, v, fv);  check("R5 actual", v, 16'h1234);
        rd(36, v, fv);  check("R4 fail bit", v, 1);

        // Next start clears the record (R5)
        wr(5, int'(init_val(5)));
        fail_step = -1;
        wr(0, 1);
        repeat (3) @(negedge clk);
        rd(32, v, fv);  check("R5 cleared idx", v, 0);
        rd(35, v, fv);  check("R5 cleared act", v, 0);
        repeat (TOTAL + 5) @(negedge clk);
        check("R3 clean rerun", int'(fail_o), 0);

        // Abort (R10): fault at k=8 then stop
        wr(9, 0);
        fail_step = 9;
        wr(0, 1);
        repeat (20) @(negedge clk);
        check("R10 fail before abort", int'(fail_o), 1);
        wr(0, 3);
        check("R10 idle", int'(busy_o), 0);
        check("R10 fail cleared", int'(fail_o), 0);
        rd(32, v, fv);  check("R10 idx cleared", v, 0);
        rd(35, v, fv);  check("R10 act cleared", v, 0);
        repeat (10) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule